// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Sorted Source Register

The block gathers 96 level-sensitive interrupt lines behind a small word-addressed register file and drives one interrupt request toward a processor. Each line has a mask bit. Software never writes a mask word directly. It sets mask bits through one write-one register per bank and clears them through another, so concurrent updates to different lines cannot collide. The lines are grouped into three banks of 32, with each bank's registers repeated at a fixed stride.

Whenever nothing is latched, the controller captures the lowest-numbered line that is both asserted and unmasked. It holds that number until software writes an acknowledge, and raises the processor request while the number is held. A status read returns the held number together with a spurious flag. The flag warns software when the held line has since dropped or been masked. A configuration register provides a self-clearing soft reset and an autoidle bit, a status register shows when the soft reset has finished, and a read-only register returns the revision.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every line is masked, nothing is latched, `cpu_irq` is low, every pending register reads 0, the status register (0x14) reads 1 and the configuration register (0x10) reads 0.
- R2: A write to the mask-set register of bank b (0x8C + 0x20*b) masks line 32*b+i for each 1 in bit i of the data. Bits written as 0 leave their mask bits unchanged.
- R3: A write to the mask-clear register of bank b (0x88 + 0x20*b) unmasks line 32*b+i for each 1 in bit i of the data. Bits written as 0 leave their mask bits unchanged.
- R4: The pending register of bank b (0x98 + 0x20*b) reads, in bit i, line 32*b+i asserted AND unmasked.
- R5: While nothing is latched, the clock edge that sees any asserted, unmasked line latches the lowest-numbered such line. `cpu_irq` is high exactly while a line is latched.
- R6: A latched number does not change until it is acknowledged, even when a lower-numbered line becomes pending.
- R7: The sorted register (0x40) reads the latched number in bits 6:0. Bit 7 is 1 when the latched line is no longer asserted-and-unmasked, and also when nothing is latched, in which case bits 6:0 read 0.
- R8: A write to 0x48 with data bit 0 set releases the latch at that edge. The next selection can happen on the following edge. A write to 0x48 with bit 0 clear has no effect.
- R9: In the configuration register (0x10), bit 0 is a read/write autoidle bit. Writing bit 1 as 1 performs a soft reset: all lines are masked, the latch is released and autoidle is cleared. Bit 1 always reads 0.
- R10: The status register bit 0 reads 0 from the soft-reset write edge until RST_CYCLES further edges have passed, and reads 1 afterwards.
- R11: The revision register (0x00) reads the major number in bits 7:4 and the minor number in bits 3:0 (default 0x20).
- R12: Reads of any unimplemented address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 96 | Level interrupt lines, bit n is line n |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 12 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The properties assume that `wr_en` is a single-cycle strobe with `addr` and `wdata` stable across the sampling edge, and that the interrupt lines change only between edges. The bench drives every input on the falling edge and holds each write for exactly one rising edge, so the properties see clean, synchronous inputs. Random line patterns are sparse, made from the AND of two random words, so the latch sees both empty and crowded pending sets. Acknowledge, mask-set and mask-clear writes are mixed in random order, and the spurious flag is exercised both by dropping a latched line and by masking it.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int unsigned BANK_W      = 32;
   localparam int unsigned BANK_STRIDE = 'h20;
   localparam int unsigned OFS_REV     = 'h00;
   localparam int unsigned OFS_CFG     = 'h10;
   localparam int unsigned OFS_STAT    = 'h14;
   localparam int unsigned OFS_SIR     = 'h40;
   localparam int unsigned OFS_ACK     = 'h48;
   localparam int unsigned OFS_MCLR    = 'h88;
   localparam int unsigned OFS_MSET    = 'h8C;
   localparam int unsigned OFS_PEND    = 'h98;
   localparam int unsigned SPUR_BIT    = 7;
endpackage

// File: rtl/lic_mask_bank.sv
module lic_mask_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= '1;
      else if (soft_rst) mask_q <= '1;
      else if (set_we)   mask_q <= mask_q | wdata;
      else if (clr_we)   mask_q <= mask_q & ~wdata;
   end

   assign pend = src & ~mask_q;
endmodule

// File: rtl/lic_pick.sv
module lic_pick #(
   parameter int unsigned N   = 96,
   parameter int unsigned IDW = $clog2(N)
) (
   input  logic [N-1:0]   pend,
   output logic           any,
   output logic [IDW-1:0] idx
);
   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            any = 1'b1;
            idx = IDW'(i);
         end
      end
   end
endmodule

// File: rtl/lic_sysctl.sv
module lic_sysctl #(
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_wdata,
   output logic       soft_rst,
   output logic       autoidle,
   output logic       rst_done
);
   localparam int unsigned CW = $clog2(RST_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   assign soft_rst = cfg_we & cfg_wdata[1];
   assign rst_done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         autoidle <= 1'b0;
      end else if (soft_rst) begin
         cnt_q    <= CW'(RST_CYCLES);
         autoidle <= 1'b0;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (cfg_we)      autoidle <= cfg_wdata[0];
      end
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
   parameter int unsigned NUM_SRC    = 96,
   parameter int unsigned ADDR_W     = 12,
   parameter logic [3:0]  REV_MAJOR  = 4'd2,
   parameter logic [3:0]  REV_MINOR  = 4'd0,
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               cpu_irq
);
   import lic_pkg::*;

   localparam int unsigned NB  = NUM_SRC / BANK_W;
   localparam int unsigned IDW = $clog2(NUM_SRC);

   if (NUM_SRC % BANK_W != 0) begin : g_bad_num
      $error("NUM_SRC must be a multiple of the bank width");
   end
   if (IDW > SPUR_BIT) begin : g_bad_idw
      $error("interrupt number must fit below the spurious flag bit");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (ADDR_W < 8 || OFS_PEND + (NB - 1) * BANK_STRIDE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the bank registers");
   end

   logic               soft_rst;
   logic               autoidle;
   logic               rst_done;
   logic               ack_we;
   logic               cfg_we;
   logic [NUM_SRC-1:0] mask_all;
   logic [NUM_SRC-1:0] pend_all;
   logic               pick_any;
   logic [IDW-1:0]     pick_idx;
   logic               lat_valid;
   logic [IDW-1:0]     lat_id;
   logic               spurious;

   assign ack_we = wr_en && (addr == ADDR_W'(OFS_ACK)) && wdata[0];
   assign cfg_we = wr_en && (addr == ADDR_W'(OFS_CFG));

   lic_sysctl #(.RST_CYCLES(RST_CYCLES)) u_sysctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (wdata[1:0]),
      .soft_rst  (soft_rst),
      .autoidle  (autoidle),
      .rst_done  (rst_done)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic set_hit;
      logic clr_hit;
      assign set_hit = wr_en && (addr == ADDR_W'(OFS_MSET + b * BANK_STRIDE));
      assign clr_hit = wr_en && (addr == ADDR_W'(OFS_MCLR + b * BANK_STRIDE));

      lic_mask_bank #(.W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .set_we   (set_hit),
         .clr_we   (clr_hit),
         .wdata    (wdata),
         .src      (irq_src[b*BANK_W +: BANK_W]),
         .mask_q   (mask_all[b*BANK_W +: BANK_W]),
         .pend     (pend_all[b*BANK_W +: BANK_W])
      );
   end

   lic_pick #(.N(NUM_SRC), .IDW(IDW)) u_pick (
      .pend (pend_all),
      .any  (pick_any),
      .idx  (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_valid <= 1'b0;
         lat_id    <= '0;
      end else if (soft_rst || ack_we) begin
         lat_valid <= 1'b0;
      end else if (!lat_valid && pick_any) begin
         lat_valid <= 1'b1;
         lat_id    <= pick_idx;
      end
   end

   assign cpu_irq  = lat_valid;
   assign spurious = !lat_valid || !pend_all[lat_id];

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_REV)) begin
         rdata[7:0] = {REV_MAJOR, REV_MINOR};
      end else if (addr == ADDR_W'(OFS_CFG)) begin
         rdata[0] = autoidle;
      end else if (addr == ADDR_W'(OFS_STAT)) begin
         rdata[0] = rst_done;
      end else if (addr == ADDR_W'(OFS_SIR)) begin
         rdata[SPUR_BIT] = spurious;
         if (lat_valid) rdata[IDW-1:0] = lat_id;
      end
      for (int b = 0; b < NB; b++) begin
         if (addr == ADDR_W'(OFS_PEND + b * BANK_STRIDE))
            rdata = pend_all[b*BANK_W +: BANK_W];
      end
   end
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
   parameter int unsigned NUM_SRC = 96,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned IDW     = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_src,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [31:0]        wdata,
   input logic               cpu_irq,
   input logic [NUM_SRC-1:0] mask_all,
   input logic [IDW-1:0]     lat_id
);
   import lic_pkg::*;

   logic ack_w, srst_w, mset0_w, mclr0_w;
   assign ack_w   = wr_en && addr == ADDR_W'(OFS_ACK) && wdata[0];
   assign srst_w  = wr_en && addr == ADDR_W'(OFS_CFG) && wdata[1];
   assign mset0_w = wr_en && addr == ADDR_W'(OFS_MSET);
   assign mclr0_w = wr_en && addr == ADDR_W'(OFS_MCLR);

   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w |=> !cpu_irq);

   assert_hold_number_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && !ack_w && !srst_w) |=> (cpu_irq && $stable(lat_id)));

   assert_take_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_irq && |(irq_src & ~mask_all) && !ack_w && !srst_w) |=> cpu_irq);

   assert_number_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (int'(lat_id) < NUM_SRC));

   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mset0_w |=> ((mask_all[31:0] & $past(wdata)) == $past(wdata)));

   assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mclr0_w |=> ((mask_all[31:0] & $past(wdata)) == 32'd0));

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst_w |=> (&mask_all && !cpu_irq));
endmodule

bind lvl_irq_ctrl lic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDW(IDW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_src  (irq_src),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .cpu_irq  (cpu_irq),
   .mask_all (mask_all),
   .lat_id   (lat_id)
);

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb;
   localparam int N = 96;
   localparam int RSTC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_src = '0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        cpu_irq;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   lvl_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
   );

   // reference state, advanced at every rising edge from the requirements
   logic [N-1:0] m_mask;
   bit           m_valid;
   int           m_id;
   int           m_rcnt;
   bit           m_auto;

   function automatic int lowest(input logic [N-1:0] p);
      for (int i = 0; i < N; i++) if (p[i]) return i;
      return -1;
   endfunction

   function automatic logic [31:0] exp_sir();
      logic [N-1:0] p;
      p = irq_src & ~m_mask;
      if (!m_valid) return 32'h80;
      return {24'd0, !p[m_id], 7'(m_id)};
   endfunction

   function automatic logic [31:0] exp_pend(input int b);
      logic [N-1:0] p;
      p = irq_src & ~m_mask;
      return p[b*32 +: 32];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = '1; m_valid = 0; m_id = 0; m_rcnt = 0; m_auto = 0;
      end else begin
         logic [N-1:0] p;
         p = irq_src & ~m_mask;
         if (wr_en && addr == 12'h010 && wdata[1]) begin
            m_mask = '1; m_valid = 0; m_auto = 0; m_rcnt = RSTC;
         end else begin
            if (wr_en && addr == 12'h048 && wdata[0]) m_valid = 0;
            else if (!m_valid && p != '0) begin m_valid = 1; m_id = lowest(p); end
            for (int b = 0; b < 3; b++) begin
               if (wr_en && addr == 12'(32'h8C + b*32)) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | wdata;
               if (wr_en && addr == 12'(32'h88 + b*32)) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~wdata;
            end
            if (wr_en && addr == 12'h010) m_auto = wdata[0];
            if (m_rcnt > 0) m_rcnt--;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic set_src(input logic [N-1:0] v);
      @(negedge clk);
      irq_src = v;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      irq_src = '1;
      // R1: reset state
      rd(12'h048, d);
      check("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
      for (int b = 0; b < 3; b++) begin
         rd(12'(32'h98 + b*32), d); check("R1 pending", d, 32'd0);
      end
      rd(12'h014, d); check("R1 status", d, 32'd1);
      rd(12'h010, d); check("R1 config", d, 32'd0);
      rd(12'h040, d); check("R7 empty sir", d, 32'h80);
      // R11, R12
      rd(12'h000, d); check("R11 revision", d, 32'h20);
      rd(12'h004, d); check("R12 unimpl", d, 32'd0);
      rd(12'h0F8, d); check("R12 unimpl past banks", d, 32'd0);
      rd(12'h084, d); check("R12 unimpl", d, 32'd0);

      // R3/R4: unmask lines 40 and 70, only 70 asserted
      set_src('0);
      wr(12'h0A8, 32'h0000_0100);
      wr(12'h0C8, 32'h0000_0040);
      set_src(96'd1 << 70);
      rd(12'h0D8, d); check("R4 pend bank2", d, 32'h40);
      rd(12'h0B8, d); check("R4 pend bank1", d, 32'h0);
      rd(12'h040, d); check("R5 sir line70", d, 32'd70);
      check("R5 cpu_irq", {31'd0, cpu_irq}, 32'd1);
      // R6: lower line arrives, number held
      set_src((96'd1 << 70) | (96'd1 << 40));
      rd(12'h040, d); check("R6 held 70", d, 32'd70);
      // R8: ack with bit0 clear ignored
      wr(12'h048, 32'h2);
      rd(12'h040, d); check("R8 ack0 ignored", d, 32'd70);
      wr(12'h048, 32'h1);
      rd(12'h040, d); check("R8 next is 40", d, 32'd40);
      // R7: drop line 40
      set_src(96'd1 << 70);
      rd(12'h040, d); check("R7 dropped", d, 32'hA8);
      set_src((96'd1 << 70) | (96'd1 << 40));
      rd(12'h040, d); check("R7 back", d, 32'd40);
      // R2: mask line 40 with zero bits around it, line 70 unaffected
      wr(12'h0AC, 32'h0000_0100);
      rd(12'h040, d); check("R7 masked", d, 32'hA8);
      rd(12'h0B8, d); check("R2 bank1 masked", d, 32'h0);
      wr(12'h0CC, 32'h0000_0000);
      rd(12'h0D8, d); check("R2 zero bits", d, 32'h40);
      wr(12'h0C8, 32'h0000_0000);
      set_src('1);
      rd(12'h0D8, d); check("R3 zero bits", d, 32'h40);

      // R9 autoidle
      wr(12'h010, 32'h1);
      rd(12'h010, d); check("R9 autoidle", d, 32'h1);
      // R9/R10 soft reset
      wr(12'h010, 32'h3);
      rd(12'h014, d); check("R10 busy", d, 32'd0);
      rd(12'h010, d); check("R9 cfg cleared", d, 32'd0);
      check("R9 cpu_irq", {31'd0, cpu_irq}, 32'd0);
      rd(12'h0D8, d); check("R9 masked", d, 32'd0);
      rd(12'h014, d); check("R10 done", d, 32'd1);

      // random phase
      for (int it = 0; it < 400; it++) begin
         int b;
         b = int'($urandom % 3);
         case ($urandom % 6)
            0: set_src({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
            1: wr(12'(32'h8C + b*32), $urandom & $urandom & $urandom);
            2: wr(12'(32'h88 + b*32), $urandom & $urandom);
            3: wr(12'h048, 32'h1);
            default: @(negedge clk);
         endcase
         rd(12'h040, d); check("R7 random sir", d, exp_sir());
         check("R5 random cpu_irq", {31'd0, cpu_irq}, {31'd0, m_valid});
         rd(12'(32'h98 + b*32), d); check("R4 random pend", d, exp_pend(b));
         if (it % 50 == 0) begin
            rd(12'h014, d); check("R10 status", d, {31'd0, m_rcnt == 0});
            rd(12'h010, d); check("R9 cfg", d, {31'd0, m_auto});
         end
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule